// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block collects up to 32 interrupt request lines from on-chip peripherals. It turns each new rising edge on an enabled line into one 32-bit memory write on a master port, so the processor gets the event as a message and not on a dedicated interrupt wire. Software sees five 32-bit registers on a small register bus. A sticky request word records the events that were enabled. An enable word picks the lines that cause messages. A capture word records every event, even on lines that are not enabled, and clears when it is read or written. A control word holds a single bit that stops message writes. A target word sets both the destination and the payload of the message.

The register bus uses word addresses. Register offset 0x00, 0x04, 0x08, 0x0C or 0x10 corresponds to word index 0, 1, 2, 3 or 4. A transfer of 1 to 4 bytes is expressed with four byte strobes in big-endian order: strobe k selects the byte at byte offset k, which is bits [31-8k -: 8] of the word. Reads always return the full word one cycle after the request. The line numbers are fixed: serial 5, parallel 7, network 8, SCSI 9, audio 13, the aggregator's own events 14, and keyboard/mouse (shared) 26. Lines 16 to 21 are general expansion lines.

Top module: `msi_irq_aggregator`

## Requirements
- R1: After reset, the request, enable, capture and control words read 0, the target word reads the parameter ADDR_RST (default 0xF000_0003), and msg_valid is 0.
- R2: A rising edge on an implemented line sets that bit of the capture word whether or not the line is enabled. A line held high counts as a single event.
- R3: A rising edge on an enabled line sets that bit of the request word and produces exactly one message write. msg_valid first goes high 5 clock edges after the edge on the input. msg_addr is the target word with bits 4:0 cleared, and msg_data is the target word's bits 4:0 zero-extended.
- R4: While bit 8 of the control word is 1, enabled edges produce no message, but the request bit is still set.
- R5: A read of the capture word (index 2) returns its value and then clears it to 0. Any write to index 2 clears it, whatever the data or strobes.
- R6: A read of the control word (index 3) returns only bit 8. All other bits read 0, whatever was written.
- R7: Only lines 5, 7, 8, 9, 13, 14, 16–21 and 26 exist. Enable bits outside this set are stored as 0, so writing 0xFFFF_FFFF reads back 0x043F_63A0. Edges on other lines change nothing.
- R8: Writes to the request word (index 0) are ignored.
- R9: Writes update only the bytes whose strobe is set, in big-endian order. Strobe 0 selects bits 31:24 and strobe 3 selects bits 7:0.
- R10: While msg_ready is low, pending messages are queued, and msg_valid and msg_addr hold steady. Lines whose edges arrive in the same cycle each produce their own message once the port accepts them.
- R11: Reads of unmapped word indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Asynchronous interrupt request lines |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word index of the register |
| reg_be | input | 4 | Byte strobes, big-endian (strobe 0 = bits 31:24) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Memory port accepts the message |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
An input edge passes through two synchroniser flops and reaches the capture and request words on the third clock edge. It enters the queue on the fourth edge and appears on msg_valid after the fifth. The bench drives lines at falling edges, checks that msg_valid is still low after edge four and high after edge five, and samples the message fields at that point. Register read data is registered, so every read is sampled at the falling edge after the edge that captured the request. Checks that a message is absent, or that a stalled message holds, watch the port over a window of 10 to 20 cycles, well past the 5-cycle latency.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

  localparam int unsigned WORD_W = 32;

  // Fixed line numbers
  localparam int unsigned LINE_SERIAL   = 5;
  localparam int unsigned LINE_PARALLEL = 7;
  localparam int unsigned LINE_NET      = 8;
  localparam int unsigned LINE_SCSI     = 9;
  localparam int unsigned LINE_AUDIO    = 13;
  localparam int unsigned LINE_SELF     = 14;
  localparam int unsigned LINE_EXP_LO   = 16;
  localparam int unsigned LINE_EXP_HI   = 21;
  localparam int unsigned LINE_HID      = 26;

  localparam int unsigned SUPPRESS_BIT  = 8;
  localparam int unsigned SLOT_BITS     = 5;

  typedef enum logic [2:0] {
    SEL_REQ, SEL_ENA, SEL_CAP, SEL_CTL, SEL_TGT, SEL_NONE
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] impl_lines();
    logic [WORD_W-1:0] m;
    m = '0;
    m[LINE_SERIAL]   = 1'b1;
    m[LINE_PARALLEL] = 1'b1;
    m[LINE_NET]      = 1'b1;
    m[LINE_SCSI]     = 1'b1;
    m[LINE_AUDIO]    = 1'b1;
    m[LINE_SELF]     = 1'b1;
    m[LINE_HID]      = 1'b1;
    for (int i = LINE_EXP_LO; i <= LINE_EXP_HI; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Big-endian byte merge: strobe k covers bits [31-8k -: 8]
  function automatic logic [WORD_W-1:0] be_merge(input logic [WORD_W-1:0] old_v,
                                                 input logic [WORD_W-1:0] new_v,
                                                 input logic [3:0]        be);
    logic [WORD_W-1:0] r;
    r = old_v;
    for (int k = 0; k < 4; k++)
      if (be[k]) r[WORD_W-1-8*k -: 8] = new_v[WORD_W-1-8*k -: 8];
    return r;
  endfunction

endpackage

// File: rtl/irq_edge_front.sv
module irq_edge_front #(
  parameter int unsigned N           = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [N-1:0] IMPL       = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines_in,
  output logic [N-1:0] rise
);

  logic [N-1:0] chain [SYNC_STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= lines_in;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain[SYNC_STAGES-1];
  end

  assign rise = chain[SYNC_STAGES-1] & ~prev_q & IMPL;

  // R2: a held level yields a one-cycle pulse only
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/irq_line_picker.sv
module irq_line_picker #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] pick
);

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_msg_fifo.sv
module irq_msg_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             pop;

  assign full = (count == CNT_W'(DEPTH));
  assign pop  = (!out_valid || out_ready) && (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pop) begin
        out_valid <= 1'b1;
        out_data  <= mem[rd_ptr];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R10: never write into a full queue
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R10: a stalled message holds steady
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/msi_irq_aggregator.sv
module msi_irq_aggregator
  import msi_agg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] ADDR_RST    = 32'hF000_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       irq_lines,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [31:0]       msg_addr,
  output logic [31:0]       msg_data
);

  localparam logic [WORD_W-1:0] IMPL = impl_lines();
  localparam logic [WORD_W-1:0] SLOT_MASK = WORD_W'((1 << SLOT_BITS) - 1);

  logic [WORD_W-1:0] req_q, ena_q, cap_q, tgt_q, todo_q;
  logic              susp_q;
  logic [WORD_W-1:0] rise, pick, grant, fifo_out;
  logic              fifo_full, push;
  reg_sel_e          sel;
  logic              rd, wr;

  irq_edge_front #(
    .N(WORD_W), .SYNC_STAGES(SYNC_STAGES), .IMPL(IMPL)
  ) u_front (
    .clk(clk), .rst(rst), .lines_in(irq_lines), .rise(rise)
  );

  irq_line_picker #(.N(WORD_W)) u_pick (
    .vec(todo_q), .pick(pick)
  );

  irq_msg_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_data(tgt_q), .full(fifo_full),
    .out_valid(msg_valid), .out_ready(msg_ready), .out_data(fifo_out)
  );

  // Address decode
  always_comb begin
    case (reg_addr)
      ADDR_W'(0): sel = SEL_REQ;
      ADDR_W'(1): sel = SEL_ENA;
      ADDR_W'(2): sel = SEL_CAP;
      ADDR_W'(3): sel = SEL_CTL;
      ADDR_W'(4): sel = SEL_TGT;
      default:    sel = SEL_NONE;
    endcase
  end

  assign rd    = reg_req && !reg_we;
  assign wr    = reg_req && reg_we;
  assign grant = fifo_full ? '0 : pick;
  assign push  = |grant;

  // Register file and event tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      ena_q  <= '0;
      cap_q  <= '0;
      susp_q <= 1'b0;
      tgt_q  <= ADDR_RST;
      todo_q <= '0;
    end else begin
      req_q <= req_q | (rise & ena_q);
      if (reg_req && sel == SEL_CAP) cap_q <= rise;
      else                           cap_q <= cap_q | rise;
      todo_q <= (todo_q & ~grant) | (susp_q ? '0 : (rise & ena_q));
      if (wr) begin
        case (sel)
          SEL_ENA: ena_q  <= be_merge(ena_q, reg_wdata, reg_be) & IMPL;
          SEL_CTL: if (reg_be[2]) susp_q <= reg_wdata[SUPPRESS_BIT];
          SEL_TGT: tgt_q  <= be_merge(tgt_q, reg_wdata, reg_be);
          default: ;
        endcase
      end
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd;
      if (rd) begin
        case (sel)
          SEL_REQ: reg_rdata <= req_q;
          SEL_ENA: reg_rdata <= ena_q;
          SEL_CAP: reg_rdata <= cap_q;
          SEL_CTL: reg_rdata <= WORD_W'(susp_q) << SUPPRESS_BIT;
          SEL_TGT: reg_rdata <= tgt_q;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assign msg_addr = fifo_out & ~SLOT_MASK;
  assign msg_data = fifo_out & SLOT_MASK;

  // R2: captured bits only drop on a capture-word access
  a_r2_cap_sticky: assert property (@(posedge clk) disable iff (rst)
    !(reg_req && sel == SEL_CAP) |=> (($past(cap_q) & ~cap_q) == '0));

  // R4: with suppression on and nothing outstanding, nothing new is queued
  a_r4_suppress: assert property (@(posedge clk) disable iff (rst)
    (susp_q && todo_q == '0) |=> (todo_q == '0));

  // R5: a capture read returns the pre-clear value
  a_r5_cap_read: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_CAP) |=> (reg_rdata == $past(cap_q)));

  // R6: control reads expose only the suppress bit
  a_r6_ctl_read: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_CTL) |=> ((reg_rdata & ~(WORD_W'(1) << SUPPRESS_BIT)) == '0));

  // R7: request word holds only implemented lines
  a_r7_req_impl: assert property (@(posedge clk) disable iff (rst)
    (req_q & ~IMPL) == '0);

  // R11: unmapped reads return zero
  a_r11_unmapped: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_NONE) |=> (reg_rdata == '0));

endmodule

// File: tb/msi_irq_aggregator_tb.sv
module msi_irq_aggregator_tb;

  localparam time CLK_PERIOD = 10;
  localparam int unsigned AW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_lines = '0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [31:0] msg_addr, msg_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_irq_aggregator #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int n_chk = 0, n_bad = 0, hs = 0;
  logic [31:0] last_a = '0, last_d = '0;
  logic [31:0] exp_req = '0;

  always @(posedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      hs++;
      last_a = msg_addr;
      last_d = msg_data;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0; reg_be = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_req = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 msg_valid", 32'(msg_valid), 32'h0);
    bus_read(0, v); check("R1 request", v, 32'h0);
    bus_read(1, v); check("R1 enable", v, 32'h0);
    bus_read(2, v); check("R1 capture", v, 32'h0);
    bus_read(3, v); check("R1 control", v, 32'h0);
    bus_read(4, v); check("R1 target", v, 32'hF000_0003);
    bus_read(9, v); check("R11 unmapped", v, 32'h0);
  endtask

  task automatic t_bytes;
    logic [31:0] v;
    bus_write(4, 4'b1000, 32'hAAAA_AA25);
    bus_read(4, v); check("R9 low byte", v, 32'hF000_0025);
    bus_write(4, 4'b0001, 32'h1255_5555);
    bus_read(4, v); check("R9 high byte", v, 32'h1200_0025);
  endtask

  task automatic t_mask_impl;
    logic [31:0] v;
    bus_write(1, 4'b1111, 32'hFFFF_FFFF);
    bus_read(1, v); check("R7 enable impl", v, 32'h043F_63A0);
    bus_write(1, 4'b1111, 32'h0);
    bus_read(2, v);
    irq_lines[0] = 1'b1; irq_lines[31] = 1'b1;
    idle(8);
    bus_read(2, v); check("R7 unimpl line", v, 32'h0);
    irq_lines[0] = 1'b0; irq_lines[31] = 1'b0;
    idle(4);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    int h0;
    h0 = hs;
    bus_read(2, v);
    irq_lines[14] = 1'b1;
    idle(8);
    bus_read(2, v); check("R2 capture masked", v, 32'h0000_4000);
    bus_read(2, v); check("R5 read clears", v, 32'h0);
    bus_read(0, v); check("R2 no request", v, exp_req);
    check("R2 no message", 32'(hs - h0), 32'h0);
    irq_lines[14] = 1'b0;
    idle(4);
    irq_lines[13] = 1'b1;
    idle(8);
    bus_write(2, 4'b0000, 32'h0000_2000);
    bus_read(2, v); check("R5 write clears", v, 32'h0);
    irq_lines[13] = 1'b0;
    idle(4);
  endtask

  task automatic t_message;
    logic [31:0] v;
    int h0;
    bus_write(4, 4'b1111, 32'h8000_0047);
    bus_write(1, 4'b1111, 32'h0000_0020);
    h0 = hs;
    @(negedge clk);
    irq_lines[5] = 1'b1;
    idle(4);
    check("R3 not yet valid", 32'(msg_valid), 32'h0);
    idle(1);
    check("R3 valid at edge 5", 32'(msg_valid), 32'h1);
    check("R3 address", msg_addr, 32'h8000_0040);
    check("R3 data", msg_data, 32'h0000_0007);
    idle(20);
    check("R3 one message per held level", 32'(hs - h0), 32'h1);
    exp_req[5] = 1'b1;
    bus_read(0, v); check("R3 request bit", v, exp_req);
    irq_lines[5] = 1'b0;
    idle(4);
  endtask

  task automatic t_suppress;
    logic [31:0] v;
    int h0;
    bus_write(3, 4'b1111, 32'hFFFF_FFFF);
    bus_read(3, v); check("R6 control read", v, 32'h0000_0100);
    bus_write(1, 4'b1111, 32'h0000_0080);
    h0 = hs;
    irq_lines[7] = 1'b1;
    idle(20);
    check("R4 no message", 32'(hs - h0), 32'h0);
    check("R4 msg_valid low", 32'(msg_valid), 32'h0);
    exp_req[7] = 1'b1;
    bus_read(0, v); check("R4 request kept", v, exp_req);
    bus_write(3, 4'b1111, 32'h0);
    irq_lines[7] = 1'b0;
    idle(4);
  endtask

  task automatic t_req_ro;
    logic [31:0] v;
    bus_write(0, 4'b1111, 32'hFFFF_FFFF);
    bus_read(0, v); check("R8 request read-only", v, exp_req);
    bus_write(0, 4'b1111, 32'h0);
    bus_read(0, v); check("R8 request not cleared", v, exp_req);
  endtask

  task automatic t_stall;
    logic [31:0] a0;
    int h0;
    bus_write(1, 4'b1111, 32'h000F_0000);
    @(negedge clk);
    msg_ready = 1'b0;
    h0 = hs;
    irq_lines[19:16] = 4'hF;
    idle(10);
    check("R10 valid while stalled", 32'(msg_valid), 32'h1);
    a0 = msg_addr;
    idle(5);
    check("R10 address held", msg_addr, a0);
    check("R10 none accepted", 32'(hs - h0), 32'h0);
    msg_ready = 1'b1;
    idle(20);
    check("R10 four messages", 32'(hs - h0), 32'h4);
    check("R10 drained", 32'(msg_valid), 32'h0);
    irq_lines[19:16] = 4'h0;
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_bytes();
    t_mask_impl();
    t_capture();
    t_message();
    t_suppress();
    t_req_ro();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule